// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block drives a successive-approximation converter. An analog comparator, a sample-and-hold and a reference DAC sit outside it. For each conversion the block raises a one-cycle sample strobe on the selected input channel. It then runs a 12-step binary search: it presents a trial code to the DAC and keeps or drops each trial bit according to the comparator answer. Each finished code is stored in a result register owned by that channel.

A start strobe launches a run in one of four modes. The single modes convert one channel, once or repeatedly. The scan modes convert a range of channels, once or repeatedly. The first channel index, last channel index and mode are captured when a run is accepted. A done pulse marks every finished conversion, and a pass-complete pulse marks the end of each scan pass. In the repeating modes a stop request ends the run cleanly, at the end of the conversion in progress.

The result registers are read through a plain combinational read port (`rd_ch_i` selects, `rd_data_o` returns). The result data are held until overwritten, so this port has no valid/ready handshake and no back-pressure.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `pass_done_o` and `sample_o` are 0, `trial_o` is 0, and every result register reads 0. While idle, `trial_o` stays 0 and `sample_o` stays 0.
- R2: A start accepted while idle produces a one-cycle `sample_o` in the very next cycle, with `chan_o` showing the channel being converted. Every conversion has exactly one sample cycle.
- R3: After the sample cycle come 12 decision cycles, MSB first. The first trial code is 0x800. A trial bit is kept when `cmp_i` is 0 (trial not larger than input) and cleared when `cmp_i` is 1. Each later trial keeps the bits decided so far. `chan_o` does not change during the decision cycles.
- R4: `done_o` is a one-cycle pulse in the cycle after the last decision, 13 cycles after the sample cycle. From that cycle on, the register of the converted channel holds the final code, which for an ideal comparator equals the input level.
- R5: `mode_i` = 0 converts channel `first_ch_i` once and then returns to idle.
- R6: `mode_i` = 1 converts channel `first_ch_i` repeatedly, back to back, until stopped.
- R7: `mode_i` = 2 converts channels from `first_ch_i` up to `last_ch_i`, incrementing modulo 8, so the range wraps when last < first. It then returns to idle. `pass_done_o` pulses together with the `done_o` of the last channel, and never pulses in the single modes.
- R8: `mode_i` = 3 repeats the scan of R7, restarting at `first_ch_i` after each pass, until stopped.
- R9: A stop request (`stop_i`) during a run takes effect at the end of the conversion in progress. A stop while idle has no effect on a later run.
- R10: A start while busy is ignored: mode, channel range and the run in progress are unchanged.
- R11: `busy_o` is high from the sample cycle through the last decision cycle of the final conversion, and low in the cycle of the final `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run (ignored while busy) |
| stop_i | input | 1 | End the run after the current conversion |
| mode_i | input | 2 | 0 single, 1 single repeat, 2 scan, 3 scan repeat |
| first_ch_i | input | 3 | First channel (the channel in single modes) |
| last_ch_i | input | 3 | Last channel of a scan |
| cmp_i | input | 1 | Comparator: 1 when trial code exceeds the held input |
| trial_o | output | 12 | Trial code to the DAC |
| sample_o | output | 1 | Sample-and-hold strobe |
| chan_o | output | 3 | Selected input channel |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Conversion finished pulse |
| pass_done_o | output | 1 | Scan pass finished pulse |
| rd_ch_i | input | 3 | Result register select |
| rd_data_o | output | 12 | Selected result register |

## Verification
A corrupted search register shows as a wrong trial code in the very next decision cycle, and as a wrong stored result 13 cycles after the sample strobe. A wrong channel counter shows at `chan_o` on the next sample strobe, and in which register is written at the next done pulse. A lost or stale stop flag, or a wrong mode decode, shows up as a run that is too long or too short. The bench compares the conversion count, the pass count and the order of sampled channels against values computed from the mode and range.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // bit 1 selects scanning a channel range, bit 0 selects looping
  typedef enum logic [1:0] {
    MODE_ONE       = 2'd0,
    MODE_ONE_LOOP  = 2'd1,
    MODE_SCAN      = 2'd2,
    MODE_SCAN_LOOP = 2'd3
  } sar_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_DECIDE = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_search.sv
module sar_search #(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           cmp_i,
  output logic [RES-1:0] trial_o,
  output logic           fin_o,
  output logic [RES-1:0] result_o
);
  localparam int IW = $clog2(RES);

  logic [RES-1:0] code_q;
  logic [IW-1:0]  idx_q;
  logic           active_q;
  logic [RES-1:0] mask;
  logic [RES-1:0] code_nxt;

  always_comb begin
    mask     = {{(RES-1){1'b0}}, 1'b1} << idx_q;
    trial_o  = active_q ? (code_q | mask) : '0;
    code_nxt = cmp_i ? code_q : (code_q | mask);
    fin_o    = active_q && (idx_q == '0);
    result_o = code_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      code_q   <= '0;
      idx_q    <= IW'(RES-1);
      active_q <= 1'b1;
    end else if (active_q) begin
      code_q <= code_nxt;
      if (idx_q == '0) active_q <= 1'b0;
      else             idx_q    <= idx_q - 1'b1;
    end
  end
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int RES = 12,
  parameter int NCH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [$clog2(NCH)-1:0] wch_i,
  input  logic [RES-1:0]         wdata_i,
  input  logic [$clog2(NCH)-1:0] rd_ch_i,
  output logic [RES-1:0]         rd_data_o
);
  logic [RES-1:0] slot_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     slot_q[g] <= '0;
      else if (we_i && wch_i == g)    slot_q[g] <= wdata_i;
    end
  end

  assign rd_data_o = slot_q[rd_ch_i];
endmodule

// File: rtl/sar_chan_seq.sv
module sar_chan_seq
  import sar_seq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic [1:0]             mode_i,
  input  logic [$clog2(NCH)-1:0] first_i,
  input  logic [$clog2(NCH)-1:0] last_i,
  input  logic                   fin_i,
  output logic                   sample_o,
  output logic [$clog2(NCH)-1:0] chan_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   pass_done_o
);
  localparam int CHW = $clog2(NCH);

  sar_state_e     state_q;
  sar_mode_e      mode_q;
  logic [CHW-1:0] first_q, last_q, chan_q;
  logic           stop_pend_q, done_q, pass_q;
  logic           is_scan, is_loop, pass_end, halt;
  logic [CHW-1:0] chan_inc;

  always_comb begin
    is_scan  = mode_q[1];
    is_loop  = mode_q[0];
    pass_end = !is_scan || (chan_q == last_q);
    halt     = stop_pend_q || stop_i || (!is_loop && pass_end);
    chan_inc = (chan_q == CHW'(NCH-1)) ? '0 : chan_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_ONE;
      first_q     <= '0;
      last_q      <= '0;
      chan_q      <= '0;
      stop_pend_q <= 1'b0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q      <= sar_mode_e'(mode_i);
            first_q     <= first_i;
            last_q      <= last_i;
            chan_q      <= first_i;
            stop_pend_q <= 1'b0;
            state_q     <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          if (stop_i) stop_pend_q <= 1'b1;
          state_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (stop_i) stop_pend_q <= 1'b1;
          if (fin_i) begin
            done_q <= 1'b1;
            pass_q <= is_scan && pass_end;
            if (halt) begin
              state_q     <= ST_IDLE;
              stop_pend_q <= 1'b0;
            end else begin
              state_q <= ST_SAMPLE;
              if (is_scan) chan_q <= pass_end ? first_q : chan_inc;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sample_o    = (state_q == ST_SAMPLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign chan_o      = chan_q;
  assign done_o      = done_q;
  assign pass_done_o = pass_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int RES = 12,
  parameter int NCH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic [1:0]             mode_i,
  input  logic [$clog2(NCH)-1:0] first_ch_i,
  input  logic [$clog2(NCH)-1:0] last_ch_i,
  input  logic                   cmp_i,
  output logic [RES-1:0]         trial_o,
  output logic                   sample_o,
  output logic [$clog2(NCH)-1:0] chan_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   pass_done_o,
  input  logic [$clog2(NCH)-1:0] rd_ch_i,
  output logic [RES-1:0]         rd_data_o
);
  logic           fin;
  logic [RES-1:0] result;

  sar_chan_seq #(.NCH(NCH)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .mode_i      (mode_i),
    .first_i     (first_ch_i),
    .last_i      (last_ch_i),
    .fin_i       (fin),
    .sample_o    (sample_o),
    .chan_o      (chan_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .pass_done_o (pass_done_o)
  );

  sar_search #(.RES(RES)) u_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (sample_o),
    .cmp_i    (cmp_i),
    .trial_o  (trial_o),
    .fin_o    (fin),
    .result_o (result)
  );

  sar_result_bank #(.RES(RES), .NCH(NCH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (fin),
    .wch_i     (chan_o),
    .wdata_i   (result),
    .rd_ch_i   (rd_ch_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES = 12,
  parameter int NCH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic [RES-1:0]         trial_o,
  input logic                   sample_o,
  input logic [$clog2(NCH)-1:0] chan_o,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   pass_done_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (trial_o == '0 && !sample_o));

  p_start_samples_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> sample_o);

  p_sample_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o);

  p_first_trial_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> (trial_o == {1'b1, {(RES-1){1'b0}}}));

  p_chan_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sample_o) |-> $stable(chan_o));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  p_pass_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done_o |-> done_o);
endmodule

bind sar_seq_top sar_seq_chk #(.RES(RES), .NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .trial_o     (trial_o),
  .sample_o    (sample_o),
  .chan_o      (chan_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pass_done_o (pass_done_o)
);

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [2:0]  first_ch_i = '0, last_ch_i = '0, rd_ch_i = '0;
  logic        cmp_i;
  logic [11:0] trial_o, rd_data_o;
  logic        sample_o, busy_o, done_o, pass_done_o;
  logic [2:0]  chan_o;

  logic [11:0] vin [8];
  int total = 0, bad = 0;
  int ndone = 0, npass = 0, nsmp = 0;
  int slog [64];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: trial larger than held input
  assign cmp_i = (trial_o > vin[chan_o]);

  sar_seq_top dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .mode_i(mode_i), .first_ch_i(first_ch_i), .last_ch_i(last_ch_i),
    .cmp_i(cmp_i), .trial_o(trial_o), .sample_o(sample_o), .chan_o(chan_o),
    .busy_o(busy_o), .done_o(done_o), .pass_done_o(pass_done_o),
    .rd_ch_i(rd_ch_i), .rd_data_o(rd_data_o)
  );

  always @(negedge clk) begin
    if (done_o) ndone = ndone + 1;
    if (pass_done_o) npass = npass + 1;
    if (sample_o) begin
      if (nsmp < 64) slog[nsmp] = int'(chan_o);
      nsmp = nsmp + 1;
    end
  end

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] first;
    logic [2:0] last;
    logic [7:0] nstop;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 3'd5, 3'd0, 8'd0},
    '{2'd2, 3'd0, 3'd7, 8'd0},
    '{2'd2, 3'd2, 3'd4, 8'd0},
    '{2'd2, 3'd6, 3'd1, 8'd0},
    '{2'd1, 3'd3, 3'd0, 8'd3},
    '{2'd3, 3'd1, 3'd2, 8'd5}
  };

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    ndone = 0; npass = 0; nsmp = 0;
  endtask

  task automatic launch(input logic [1:0] m, input logic [2:0] f, input logic [2:0] l);
    mode_i = m; first_ch_i = f; last_ch_i = l; start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) tick();
    tick();
  endtask

  function automatic int scan_len(input int f, input int l);
    return ((l - f + 8) % 8) + 1;
  endfunction

  function automatic int exp_ch(input int m, input int f, input int l, input int k);
    if (m < 2) return f;
    return (f + (k % scan_len(f, l))) % 8;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 8; c++) vin[c] = '0;
    repeat (3) tick();
    // R1 reset state
    chk(!busy_o && !done_o && !pass_done_o && !sample_o, "R1 idle flags", int'(busy_o), 0);
    chk(trial_o == 0, "R1 trial zero", int'(trial_o), 0);
    begin
      int nz = 0;
      for (int c = 0; c < 8; c++) begin
        rd_ch_i = 3'(c); #1;
        if (rd_data_o != 0) nz++;
      end
      chk(nz == 0, "R1 results zero", nz, 0);
    end
    rst_n = 1'b1;
    tick();

    // table-driven runs (R5 R6 R7 R8 R9 R4)
    for (int i = 0; i < 6; i++) begin
      int m, f, l, ns, ecount, epass, miss, rbad;
      m = int'(VECS[i].mode); f = int'(VECS[i].first);
      l = int'(VECS[i].last); ns = int'(VECS[i].nstop);
      for (int c = 0; c < 8; c++) vin[c] = 12'((c * 523 + i * 1111 + 7) % 4096);
      clear_log();
      launch(VECS[i].mode, VECS[i].first, VECS[i].last);
      if (m[0]) begin
        while (ndone < ns) tick();
        stop_i = 1'b1; tick(); stop_i = 1'b0;
        ecount = ns + 1;
      end else begin
        ecount = (m == 0) ? 1 : scan_len(f, l);
      end
      wait_idle();
      epass = 0;
      if (m >= 2)
        for (int k = 0; k < ecount; k++)
          if (k % scan_len(f, l) == scan_len(f, l) - 1) epass++;
      chk(ndone == ecount, "R5/R6/R8/R9 conversion count", ndone, ecount);
      chk(npass == epass, "R7 pass pulses", npass, epass);
      miss = 0;
      for (int k = 0; k < ecount && k < 64; k++)
        if (slog[k] != exp_ch(m, f, l, k)) miss++;
      chk(miss == 0 && nsmp == ecount, "R7 R8 channel order", nsmp, ecount);
      rbad = 0;
      for (int k = 0; k < ecount; k++) begin
        rd_ch_i = 3'(exp_ch(m, f, l, k)); #1;
        if (rd_data_o != vin[rd_ch_i]) rbad++;
      end
      chk(rbad == 0, "R4 stored results", rbad, 0);
    end

    // R2 R3 R4 R11 cycle timing, input at zero
    vin[4] = 12'd0;
    clear_log();
    launch(2'd0, 3'd4, 3'd0);
    chk(sample_o && chan_o == 3'd4, "R2 sample in next cycle", int'(sample_o), 1);
    tick();
    chk(trial_o == 12'h800, "R3 first trial", int'(trial_o), 'h800);
    tick();
    chk(trial_o == 12'h400, "R3 msb cleared", int'(trial_o), 'h400);
    repeat (10) tick();
    chk(busy_o && !done_o, "R11 busy through last decision", int'(done_o), 0);
    tick();
    chk(done_o && !busy_o, "R4 done 13 cycles after sample", int'(done_o), 1);
    rd_ch_i = 3'd4; #1;
    chk(rd_data_o == 12'd0, "R4 zero input", int'(rd_data_o), 0);
    tick();
    chk(!done_o && ndone == 1, "R4 done single pulse", ndone, 1);

    // R3 full-scale input keeps bits
    vin[6] = 12'hFFF;
    launch(2'd0, 3'd6, 3'd0);
    tick(); tick();
    chk(trial_o == 12'hC00, "R3 msb kept", int'(trial_o), 'hC00);
    wait_idle();
    rd_ch_i = 3'd6; #1;
    chk(rd_data_o == 12'hFFF, "R3 full scale", int'(rd_data_o), 'hFFF);

    // R10 start while busy ignored
    for (int c = 0; c < 8; c++) vin[c] = 12'(c * 300 + 11);
    clear_log();
    launch(2'd2, 3'd0, 3'd3);
    repeat (5) tick();
    mode_i = 2'd1; first_ch_i = 3'd7; start_i = 1'b1; tick(); start_i = 1'b0;
    wait_idle();
    chk(ndone == 4 && nsmp == 4 && slog[3] == 3, "R10 start while busy", ndone, 4);

    // R9 stop while idle has no effect
    stop_i = 1'b1; tick(); stop_i = 1'b0;
    clear_log();
    launch(2'd1, 3'd2, 3'd0);
    while (ndone < 3) tick();
    chk(busy_o, "R9 idle stop ignored", int'(busy_o), 1);
    stop_i = 1'b1; tick(); stop_i = 1'b0;
    wait_idle();
    chk(ndone == 4, "R6 R9 stop at end of conversion", ndone, 4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule